// File: doc/BRIEF.md
# Branch Target Buffer

This block predicts the next fetch address while the instruction at the current fetch address is being read. It is a fully associative table that holds only branches known to be taken. Each entry keeps the complete branch address as its tag and the address the branch jumped to last time. If the fetch address matches a valid tag, the stored target becomes the next fetch address in the same cycle. If nothing matches, fetch moves on to the next sequential address.

When a branch resolves later in the pipeline, the execute stage reports four things: the branch address, whether the branch was taken, its real target, and whether the branch hit at fetch. The block then adds, rewrites, deletes or keeps the entry for that branch. One cycle later it drives a kill/redirect pulse with the corrected fetch address. It also drives a penalty count so a testbench can account for lost fetch cycles.

If an insert finds no free entry, the block replaces entries in round-robin order. An insert always takes the lowest-numbered free entry first.

Top module: `btb_top`

## Requirements
- R1: A prediction uses a stored target only when every bit of `fetch_pc_i` equals a valid entry's tag. In that case `pred_hit_o`=1 and `pred_pc_o` is that entry's target, combinationally in the same cycle.
- R2: When no valid tag matches, `pred_hit_o`=0 and `pred_pc_o` = `fetch_pc_i` + `INSTR_BYTES` (4).
- R3: A resolve with hit=1, taken=1 and a target equal to the stored one leaves the table unchanged. In the next cycle `redirect_o`=0 and `penalty_o`=0.
- R4: A resolve with hit=1 and taken=0 deletes the entry. In the next cycle `redirect_o`=1, `redirect_pc_o` = branch address + 4 and `penalty_o`=2. From then on, fetching that address misses.
- R5: A resolve with hit=0 and taken=1 stores the branch address and target. In the next cycle `redirect_o`=1, `redirect_pc_o` = the actual target and `penalty_o`=2.
- R6: A resolve with hit=0 and taken=0 stores nothing. In the next cycle `redirect_o`=0 and `penalty_o`=0.
- R7: A resolve with hit=1, taken=1 and a target different from the stored one rewrites the stored target. In the next cycle `redirect_o`=1, `redirect_pc_o` = the actual target and `penalty_o`=2.
- R8: An insert takes the lowest-indexed invalid entry. When all entries are valid, it replaces the entry under a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, only on such a replacement. An insert or rewrite of an address that is already stored reuses that entry.
- R9: Reset clears every valid bit. While reset is held and after it is released, every fetch misses and `redirect_o`=0, `penalty_o`=0.
- R10: Resolve results appear only in the cycle after `res_valid_i` is sampled. Without a resolve, `redirect_o` and `penalty_o` are 0. A table change is visible to fetch lookups from that next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | Current fetch address |
| pred_hit_o | output | 1 | Fetch address found in the table |
| pred_pc_o | output | PC_W | Predicted next fetch address |
| res_valid_i | input | 1 | A branch resolution is presented |
| res_pc_i | input | PC_W | Address of the resolved branch |
| res_taken_i | input | 1 | Actual direction, 1 = taken |
| res_target_i | input | PC_W | Actual taken target |
| res_hit_i | input | 1 | The branch hit in the table at fetch |
| redirect_o | output | 1 | Kill the fetched instruction and restart fetch |
| redirect_pc_o | output | PC_W | Restart address |
| penalty_o | output | 2 | Penalty cycles charged to this resolution |

## Verification
Prediction is combinational, so the bench samples `pred_hit_o` and `pred_pc_o` one time step after changing `fetch_pc_i`, in the same half cycle. Resolutions are driven at a falling edge and captured at the next rising edge. The bench therefore checks `redirect_o`, `redirect_pc_o` and `penalty_o` at the following falling edge. At that same point it probes the resolved address through the fetch port to confirm the table change. A reference table in the bench, including its own round-robin pointer, supplies every expected value. Directed sequences cover filling, replacement and reuse of freed entries, and seeded random resolutions cover the rest.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [2:0] {
    RES_NONE, RES_GOOD, RES_TGT_FIX, RES_FALSE_HIT, RES_NEW, RES_QUIET
  } res_kind_e;

  function automatic logic [1:0] penalty_of(res_kind_e k);
    // one cycle to write the table, one to restart fetch
    return (k == RES_TGT_FIX || k == RES_FALSE_HIT || k == RES_NEW) ? 2'd2 : 2'd0;
  endfunction
endpackage

// File: rtl/btb_cam.sv
module btb_cam #(
  parameter int unsigned N     = 16,
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_i,
  input  logic [W-1:0]     tag_i [N],
  input  logic [W-1:0]     key_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             take_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] rr_q, free_idx;
  logic             full;

  assign full = &valid_i;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign idx_o = full ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (take_i && full) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int unsigned ENTRIES     = 16,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned INSTR_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_hit_o,
  output logic [PC_W-1:0] pred_pc_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic            res_hit_i,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [1:0]      penalty_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  logic [ENTRIES-1:0] valid_q;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  logic             f_hit, r_hit;
  logic [IDX_W-1:0] f_idx, r_idx, vic_idx, wr_idx;

  btb_cam #(.N(ENTRIES), .W(PC_W)) i_fetch_cam (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(fetch_pc_i), .hit_o(f_hit), .idx_o(f_idx)
  );

  btb_cam #(.N(ENTRIES), .W(PC_W)) i_res_cam (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(res_pc_i), .hit_o(r_hit), .idx_o(r_idx)
  );

  assign pred_hit_o = f_hit;
  assign pred_pc_o  = f_hit ? tgt_q[f_idx] : fetch_pc_i + STEP;

  res_kind_e       kind;
  logic            do_wr, do_del, alloc;
  logic [PC_W-1:0] fix_pc;

  always_comb begin
    kind   = RES_NONE;
    do_wr  = 1'b0;
    do_del = 1'b0;
    fix_pc = res_target_i;
    if (res_valid_i) begin
      unique case ({res_hit_i, res_taken_i})
        2'b11: begin
          if (r_hit && tgt_q[r_idx] == res_target_i) kind = RES_GOOD;
          else begin
            kind  = RES_TGT_FIX;
            do_wr = 1'b1;
          end
        end
        2'b10: begin
          kind   = RES_FALSE_HIT;
          do_del = r_hit;
          fix_pc = res_pc_i + STEP;
        end
        2'b01: begin
          kind  = RES_NEW;
          do_wr = 1'b1;
        end
        default: kind = RES_QUIET;
      endcase
    end
  end

  assign alloc  = do_wr && !r_hit;
  assign wr_idx = r_hit ? r_idx : vic_idx;

  btb_victim #(.N(ENTRIES)) i_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_q), .take_i(alloc), .idx_o(vic_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (do_wr) begin
      valid_q[wr_idx] <= 1'b1;
    end else if (do_del) begin
      valid_q[r_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else if (do_wr) begin
      tag_q[wr_idx] <= res_pc_i;
      tgt_q[wr_idx] <= res_target_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      penalty_o     <= '0;
    end else begin
      redirect_o    <= penalty_of(kind) != 2'd0;
      redirect_pc_o <= fix_pc;
      penalty_o     <= penalty_of(kind);
    end
  end
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned INSTR_BYTES = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            pred_hit_o,
  input logic [PC_W-1:0] pred_pc_o,
  input logic            res_valid_i,
  input logic [PC_W-1:0] res_pc_i,
  input logic            res_taken_i,
  input logic [PC_W-1:0] res_target_i,
  input logic            res_hit_i,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic [1:0]      penalty_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  p_seq_on_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> pred_pc_o == fetch_pc_i + STEP);

  p_false_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_hit_i && !res_taken_i |=>
      redirect_o && penalty_o == 2'd2 && redirect_pc_o == $past(res_pc_i) + STEP);

  p_deleted_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_hit_i && !res_taken_i |=>
      (fetch_pc_i != $past(res_pc_i)) || !pred_hit_o);

  p_new_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !res_hit_i && res_taken_i |=>
      redirect_o && penalty_o == 2'd2 && redirect_pc_o == $past(res_target_i));

  p_stored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_taken_i |=>
      (fetch_pc_i != $past(res_pc_i)) || (pred_hit_o && pred_pc_o == $past(res_target_i)));

  p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !res_hit_i && !res_taken_i |=> !redirect_o && penalty_o == 2'd0);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> !redirect_o && penalty_o == 2'd0);
endmodule

bind btb_top btb_checker #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) i_btb_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_pc_i(fetch_pc_i), .pred_hit_o(pred_hit_o),
  .pred_pc_o(pred_pc_o), .res_valid_i(res_valid_i), .res_pc_i(res_pc_i),
  .res_taken_i(res_taken_i), .res_target_i(res_target_i), .res_hit_i(res_hit_i),
  .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .penalty_o(penalty_o)
);

// File: tb/test_btb_top.sv
module test_btb_top;
  localparam int N = 16;
  localparam int W = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  fetch_pc_i = '0;
  logic          pred_hit_o;
  logic [W-1:0]  pred_pc_o;
  logic          res_valid_i = 1'b0;
  logic [W-1:0]  res_pc_i = '0;
  logic          res_taken_i = 1'b0;
  logic [W-1:0]  res_target_i = '0;
  logic          res_hit_i = 1'b0;
  logic          redirect_o;
  logic [W-1:0]  redirect_pc_o;
  logic [1:0]    penalty_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic          m_valid [N];
  logic [W-1:0]  m_tag [N];
  logic [W-1:0]  m_tgt [N];
  int            m_rr;

  always #4 clk_i = ~clk_i;

  btb_top i_btb_top (.*);

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int m_find(logic [W-1:0] pc);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
    return -1;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    m_rr = 0;
  endtask

  // probe the table through the fetch port (combinational lookup)
  task automatic probe(logic [W-1:0] pc, string req);
    int k;
    fetch_pc_i = pc;
    #1;
    k = m_find(pc);
    if (k >= 0) begin
      chk(pred_hit_o == 1'b1, req, W'(pred_hit_o), 1);
      chk(pred_pc_o == m_tgt[k], req, pred_pc_o, m_tgt[k]);
    end else begin
      chk(pred_hit_o == 1'b0, req, W'(pred_hit_o), 0);
      chk(pred_pc_o == pc + 4, req, pred_pc_o, pc + 4);
    end
  endtask

  task automatic resolve(logic [W-1:0] pc, bit taken, logic [W-1:0] tgt, string req);
    int k, v;
    bit hit, exp_red;
    logic [W-1:0] exp_pc;
    logic [1:0] exp_pen;
    @(negedge clk_i);
    k = m_find(pc);
    hit = (k >= 0);
    res_valid_i = 1; res_pc_i = pc; res_taken_i = taken; res_target_i = tgt; res_hit_i = hit;
    exp_red = 0; exp_pc = '0;
    if (hit && taken) begin
      if (m_tgt[k] != tgt) begin exp_red = 1; exp_pc = tgt; m_tgt[k] = tgt; end
    end else if (hit && !taken) begin
      exp_red = 1; exp_pc = pc + 4; m_valid[k] = 0;
    end else if (!hit && taken) begin
      exp_red = 1; exp_pc = tgt;
      v = m_victim();
      if (v < 0) begin v = m_rr; m_rr = (m_rr + 1) % N; end
      m_valid[v] = 1; m_tag[v] = pc; m_tgt[v] = tgt;
    end
    exp_pen = exp_red ? 2'd2 : 2'd0;
    @(negedge clk_i);
    res_valid_i = 0;
    chk(redirect_o == exp_red, req, W'(redirect_o), W'(exp_red));
    chk(penalty_o == exp_pen, req, W'(penalty_o), W'(exp_pen));
    if (exp_red) chk(redirect_pc_o == exp_pc, req, redirect_pc_o, exp_pc);
    probe(pc, req);
  endtask

  function automatic logic [W-1:0] apc(int i);
    return 32'h0000_1000 + 32'(i) * 4;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    m_clear();
    repeat (3) @(negedge clk_i);
    probe(apc(0), "R9 fetch during reset");
    chk(redirect_o == 0 && penalty_o == 0, "R9 outputs in reset", W'(penalty_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    probe(apc(3), "R9 empty after reset");
    @(negedge clk_i);
    chk(redirect_o == 0 && penalty_o == 0, "R10 idle", W'(redirect_o), 0);

    // basic kinds
    resolve(apc(0), 1, 32'h8000, "R5 miss taken insert");
    probe(apc(0) | 32'h0010_0000, "R1 full tag mismatch");
    probe(apc(0), "R1 hit target");
    resolve(apc(0), 1, 32'h8000, "R3 hit taken same target");
    resolve(apc(0), 1, 32'h9000, "R7 target rewrite");
    resolve(apc(0), 0, 32'h9000, "R4 false hit delete");
    resolve(apc(1), 0, 32'h7000, "R6 miss not taken");
    probe(apc(2), "R2 sequential");

    // fill and replace
    for (int i = 0; i < N; i++) resolve(apc(i), 1, 32'h8000 + 32'(i) * 16, "R8 fill");
    resolve(apc(16), 1, 32'hA000, "R8 replace rr0");
    probe(apc(0), "R8 slot0 evicted");
    resolve(apc(17), 1, 32'hA100, "R8 replace rr1");
    probe(apc(1), "R8 slot1 evicted");
    resolve(apc(5), 0, 32'h0, "R4 free slot5");
    resolve(apc(18), 1, 32'hA200, "R8 lowest free reused");
    probe(apc(6), "R8 neighbour intact");
    resolve(apc(19), 1, 32'hA300, "R8 replace rr2");
    probe(apc(2), "R8 slot2 evicted");
    probe(apc(18), "R8 slot5 holds new");

    // seeded random resolutions
    for (int it = 0; it < 800; it++) begin
      logic [W-1:0] pc, tg;
      pc = apc($urandom_range(0, 23));
      tg = 32'h8000 + 32'($urandom_range(0, 3)) * 4;
      resolve(pc, ($urandom_range(0, 2) != 0), tg, "R10 random resolve");
      @(negedge clk_i);
      probe(apc($urandom_range(0, 23)), "R1 random lookup");
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule